// File: doc/BRIEF.md
# Readout Channel Selection Combiner

For each event, this block decides which ADC channels are read out. It starts from a per-channel hit mask and merges in the channels that carry tracklets or tracklet candidates, according to a selectable policy. The result can then be limited by a static channel enable mask. Channels in a static always-send mask can then be added back. A built-in event counter can also force an all-channel readout every 128, 256 or 1024 events.

The block takes one event strobe per accepted event, with all input masks valid in that cycle. One cycle later it presents a registered channel mask, a valid pulse, a flag for forced full events, and a flag telling the framer to drop the per-module header. The header flag is raised only when header suppression is enabled and no channel ended up selected.

Top module: `chan_select_top`

## Requirements
- R1: With policy code 0, and also with reserved code 3, the policy result is the hit mask with every channel removed that is set in either the tracklet mask or the candidate mask.
- R2: With policy code 1, the policy result is the hit mask ORed with the tracklet mask.
- R3: With policy code 2, the policy result is the hit mask ORed with the candidate mask.
- R4: When `and_en` is 1, the policy result is ANDed with `adc_en_mask`. When `and_en` is 0, that mask has no effect.
- R5: When `or_en` is 1, `keep_mask` is ORed in after the AND step, so those channels are always selected. When `or_en` is 0, `keep_mask` has no effect.
- R6: `full_mode` codes 0/1/2/3 mean: no forced readout, every 128, every 256, and every 1024 events. An event is forced when its counter value ANDed with the period mask (2^N-1) is zero.
- R7: On a forced event, `sel_mask` is all ones and `full_evt` is 1, whatever the other masks and options are.
- R8: The event counter is zero after reset and advances by one on every strobe, so the first event after reset is forced whenever `full_mode` is not 0.
- R9: `hdr_skip` is 1 exactly when `hdr_sup_en` was 1 and the final mask is all zeros.
- R10: `sel_valid` is a single-cycle pulse in the cycle after `evt_stb`. `sel_mask`, `full_evt` and `hdr_skip` change only in that cycle and hold their value between events.
- R11: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_stb | input | 1 | One-cycle strobe marking an accepted event |
| hit_mask | input | NCH | Zero-suppression hit per channel |
| trk_mask | input | NCH | Channels holding tracklets |
| cand_mask | input | NCH | Channels holding tracklet candidates |
| adc_en_mask | input | NCH | Static channel enable mask |
| keep_mask | input | NCH | Static always-send mask |
| policy | input | 2 | Tracklet channel policy code |
| and_en | input | 1 | Enable the AND with `adc_en_mask` |
| or_en | input | 1 | Enable the OR with `keep_mask` |
| full_mode | input | 2 | Forced full readout period code |
| hdr_sup_en | input | 1 | Allow header suppression for empty events |
| sel_mask | output | NCH | Final channel selection |
| sel_valid | output | 1 | Output valid pulse |
| full_evt | output | 1 | Current result is a forced full event |
| hdr_skip | output | 1 | Drop the module header for this event |

## Verification
The assertions assume that every mask and option input is stable and meaningful in the cycle that `evt_stb` is high. They also assume that strobes are single-cycle pulses, which the counter and valid checks depend on. The bench drives all inputs at the falling edge, raises the strobe for exactly one cycle per event, and keeps it low for at least one cycle between events. Forced-period tests start from a fresh reset, so the counter value for each event is known.

// File: rtl/chan_sel_pkg.sv
// Shared encodings for the readout channel selection combiner.
// Assumes: the 2-bit codes below are the ones the configuration supplies.
package chan_sel_pkg;
    typedef enum logic [1:0] {
        POL_EXCL     = 2'd0,
        POL_ADD_TRK  = 2'd1,
        POL_ADD_CAND = 2'd2,
        POL_RSVD     = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        FULL_OFF   = 2'd0,
        FULL_SHORT = 2'd1,
        FULL_MID   = 2'd2,
        FULL_LONG  = 2'd3
    } full_e;
endpackage

// File: rtl/cs_policy.sv
// Tracklet policy stage: merges or removes tracklet/candidate channels
// relative to the hit mask. Purely combinational.
// Assumes: inputs are stable while the event strobe is high.
module cs_policy
    import chan_sel_pkg::*;
#(
    parameter int NCH = 21
) (
    input  logic [NCH-1:0] hit_mask,
    input  logic [NCH-1:0] trk_mask,
    input  logic [NCH-1:0] cand_mask,
    input  logic [1:0]     policy,
    output logic [NCH-1:0] pol_mask
);
    pol_e pol;

    // Decode the policy code and form the merged mask.
    always_comb begin
        pol = pol_e'(policy);
        case (pol)
            POL_ADD_TRK:  pol_mask = hit_mask | trk_mask;
            POL_ADD_CAND: pol_mask = hit_mask | cand_mask;
            default:      pol_mask = hit_mask & ~(trk_mask | cand_mask);
        endcase
    end

    // R1
    excl_no_trk_chk: assert final ((pol != POL_EXCL) || ((pol_mask & trk_mask) == '0));
endmodule

// File: rtl/cs_mask_stage.sv
// Mask stage: optional AND with the channel enable mask, then optional OR
// with the always-send mask, then override to all ones on a forced event.
// Assumes: force_full comes from the event counter for the current event.
module cs_mask_stage #(
    parameter int NCH = 21
) (
    input  logic [NCH-1:0] pol_mask,
    input  logic           and_en,
    input  logic [NCH-1:0] adc_en_mask,
    input  logic           or_en,
    input  logic [NCH-1:0] keep_mask,
    input  logic           force_full,
    output logic [NCH-1:0] final_mask
);
    logic [NCH-1:0] and_stage;
    logic [NCH-1:0] or_stage;

    // Apply the enable AND, the keep OR, and the forced override in order.
    always_comb begin
        and_stage  = and_en ? (pol_mask & adc_en_mask) : pol_mask;
        or_stage   = or_en ? (and_stage | keep_mask) : and_stage;
        final_mask = force_full ? {NCH{1'b1}} : or_stage;
    end

    // R5
    keep_after_and_chk: assert final (!or_en || ((final_mask & keep_mask) == keep_mask));
endmodule

// File: rtl/cs_evt_counter.sv
// Event counter with forced full readout decode. The counter starts at zero
// and advances once per strobe; an event is forced when the low bits picked
// by the period selected in full_mode are all zero.
// Assumes: evt_stb is a single-cycle pulse per accepted event.
module cs_evt_counter
    import chan_sel_pkg::*;
#(
    parameter int LOG_SHORT = 7,
    parameter int LOG_MID   = 8,
    parameter int LOG_LONG  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_stb,
    input  logic [1:0] full_mode,
    output logic       force_full
);
    localparam int CNT_W = LOG_LONG;
    localparam logic [CNT_W-1:0] MSK_SHORT = CNT_W'((64'd1 << LOG_SHORT) - 64'd1);
    localparam logic [CNT_W-1:0] MSK_MID   = CNT_W'((64'd1 << LOG_MID) - 64'd1);
    localparam logic [CNT_W-1:0] MSK_LONG  = CNT_W'((64'd1 << LOG_LONG) - 64'd1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_mask;

    // Count accepted events.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (evt_stb) cnt_q <= cnt_q + 1'b1;
    end

    // Select the period mask and decode the forced event.
    always_comb begin
        case (full_e'(full_mode))
            FULL_SHORT: per_mask = MSK_SHORT;
            FULL_MID:   per_mask = MSK_MID;
            FULL_LONG:  per_mask = MSK_LONG;
            default:    per_mask = '0;
        endcase
        force_full = (full_mode != 2'd0) && ((cnt_q & per_mask) == '0);
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_stb |=> $stable(cnt_q));
endmodule

// File: rtl/chan_select_top.sv
// Readout channel selection combiner top. Chains the policy stage, the mask
// stage and the event counter, and registers the result one cycle after the
// event strobe together with the valid, forced and header-skip flags.
// Assumes: all masks and options are valid in the strobe cycle.
module chan_select_top #(
    parameter int NCH       = 21,
    parameter int LOG_SHORT = 7,
    parameter int LOG_MID   = 8,
    parameter int LOG_LONG  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_stb,
    input  logic [NCH-1:0] hit_mask,
    input  logic [NCH-1:0] trk_mask,
    input  logic [NCH-1:0] cand_mask,
    input  logic [NCH-1:0] adc_en_mask,
    input  logic [NCH-1:0] keep_mask,
    input  logic [1:0]     policy,
    input  logic           and_en,
    input  logic           or_en,
    input  logic [1:0]     full_mode,
    input  logic           hdr_sup_en,
    output logic [NCH-1:0] sel_mask,
    output logic           sel_valid,
    output logic           full_evt,
    output logic           hdr_skip
);
    logic [NCH-1:0] pol_mask;
    logic [NCH-1:0] final_mask;
    logic           force_full;

    cs_policy #(.NCH(NCH)) u_policy (
        .hit_mask  (hit_mask),
        .trk_mask  (trk_mask),
        .cand_mask (cand_mask),
        .policy    (policy),
        .pol_mask  (pol_mask)
    );

    cs_evt_counter #(
        .LOG_SHORT (LOG_SHORT),
        .LOG_MID   (LOG_MID),
        .LOG_LONG  (LOG_LONG)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_stb    (evt_stb),
        .full_mode  (full_mode),
        .force_full (force_full)
    );

    cs_mask_stage #(.NCH(NCH)) u_mask (
        .pol_mask    (pol_mask),
        .and_en      (and_en),
        .adc_en_mask (adc_en_mask),
        .or_en       (or_en),
        .keep_mask   (keep_mask),
        .force_full  (force_full),
        .final_mask  (final_mask)
    );

    // Capture the result and flags on each event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mask <= '0;
            full_evt <= 1'b0;
            hdr_skip <= 1'b0;
        end else if (evt_stb) begin
            sel_mask <= final_mask;
            full_evt <= force_full;
            hdr_skip <= hdr_sup_en && (final_mask == '0);
        end
    end

    // Generate the single-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_valid <= 1'b0;
        else        sel_valid <= evt_stb;
    end

    // R7
    full_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && full_evt) |-> (&sel_mask));
    // R9
    skip_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_skip |-> (sel_mask == '0));
    // R10
    valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb |=> sel_valid);
    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_stb |=> (!sel_valid && $stable(sel_mask) && $stable(hdr_skip)));
    // R4
    and_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stb && and_en && !or_en) |=> (full_evt || ((sel_mask & ~$past(adc_en_mask)) == '0)));
endmodule

// File: tb/sim_chan_select_top.sv
module sim_chan_select_top;
    localparam int NCH = 21;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           evt_stb = 1'b0;
    logic [NCH-1:0] hit_mask = '0, trk_mask = '0, cand_mask = '0;
    logic [NCH-1:0] adc_en_mask = '0, keep_mask = '0;
    logic [1:0]     policy = 2'd0, full_mode = 2'd0;
    logic           and_en = 1'b0, or_en = 1'b0, hdr_sup_en = 1'b0;
    logic [NCH-1:0] sel_mask;
    logic           sel_valid, full_evt, hdr_skip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chan_select_top #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb),
        .hit_mask(hit_mask), .trk_mask(trk_mask), .cand_mask(cand_mask),
        .adc_en_mask(adc_en_mask), .keep_mask(keep_mask), .policy(policy),
        .and_en(and_en), .or_en(or_en), .full_mode(full_mode),
        .hdr_sup_en(hdr_sup_en), .sel_mask(sel_mask), .sel_valid(sel_valid),
        .full_evt(full_evt), .hdr_skip(hdr_skip)
    );

    typedef struct packed {
        logic [1:0]     pol;
        logic           an;
        logic           on;
        logic           sup;
        logic [NCH-1:0] hit;
        logic [NCH-1:0] adc;
        logic [NCH-1:0] exp;
        logic           exph;
    } vec_t;

    // Fixed masks for the table: trk=0x203, cand=0x633, keep=0x100001
    localparam logic [NCH-1:0] TRK  = 21'h000203;
    localparam logic [NCH-1:0] CAND = 21'h000633;
    localparam logic [NCH-1:0] KEEP = 21'h100001;

    localparam vec_t TBL [0:10] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h0000C0, 1'b0}, // R1
        '{2'd1, 1'b0, 1'b0, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h0002F3, 1'b0}, // R2
        '{2'd2, 1'b0, 1'b0, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h0006F3, 1'b0}, // R3
        '{2'd2, 1'b1, 1'b0, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h000603, 1'b0}, // R4
        '{2'd2, 1'b1, 1'b1, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h100603, 1'b0}, // R5
        '{2'd1, 1'b0, 1'b1, 1'b0, 21'h0000F0, 21'h000000, 21'h1002F3, 1'b0}, // R5
        '{2'd0, 1'b0, 1'b0, 1'b1, 21'h000030, 21'h1FFF0F, 21'h000000, 1'b1}, // R9
        '{2'd0, 1'b0, 1'b0, 1'b0, 21'h000030, 21'h1FFF0F, 21'h000000, 1'b0}, // R9
        '{2'd0, 1'b0, 1'b1, 1'b1, 21'h000030, 21'h1FFF0F, 21'h100001, 1'b0}, // R9
        '{2'd3, 1'b0, 1'b0, 1'b0, 21'h0000F0, 21'h1FFF0F, 21'h0000C0, 1'b0}, // R1
        '{2'd1, 1'b1, 1'b0, 1'b1, 21'h0000F0, 21'h000000, 21'h000000, 1'b1}  // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one event; return at the falling edge where outputs are valid.
    task automatic send_evt();
        @(negedge clk);
        evt_stb = 1'b1;
        @(negedge clk);
        evt_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 mask", 32'(sel_mask), 32'h0);
        chk("R11 valid", 32'(sel_valid), 32'h0);
        chk("R11 hdr", 32'(hdr_skip), 32'h0);
        chk("R11 full", 32'(full_evt), 32'h0);

        trk_mask = TRK; cand_mask = CAND; keep_mask = KEEP; full_mode = 2'd0;
        for (int i = 0; i < 11; i++) begin
            policy = TBL[i].pol; and_en = TBL[i].an; or_en = TBL[i].on;
            hdr_sup_en = TBL[i].sup; hit_mask = TBL[i].hit; adc_en_mask = TBL[i].adc;
            send_evt();
            chk("R1-5 table mask", 32'(sel_mask), 32'(TBL[i].exp));
            chk("R9 table hdr", 32'(hdr_skip), 32'(TBL[i].exph));
            chk("R10 valid", 32'(sel_valid), 32'h1);
            chk("R6 off no force", 32'(full_evt), 32'h0);
        end

        // R10: outputs hold and valid drops while inputs change with no strobe
        hit_mask = 21'h0F0F0F; hdr_sup_en = 1'b0;
        @(negedge clk);
        chk("R10 valid low", 32'(sel_valid), 32'h0);
        chk("R10 mask held", 32'(sel_mask), 32'h0);
        chk("R10 hdr held", 32'(hdr_skip), 32'h1);

        // R6/R7/R8: period 128
        do_reset();
        full_mode = 2'd1; policy = 2'd0; and_en = 1'b1; adc_en_mask = '0;
        or_en = 1'b0; hit_mask = 21'h0000F0; hdr_sup_en = 1'b1;
        for (int e = 0; e <= 128; e++) begin
            send_evt();
            if (e == 0 || e == 128) begin
                chk("R8 forced", 32'(full_evt), 32'h1);
                chk("R7 all ones", 32'(sel_mask), 32'h1FFFFF);
                chk("R9 no skip on full", 32'(hdr_skip), 32'h0);
            end else if (e == 1 || e == 127) begin
                chk("R6 128 not forced", 32'(full_evt), 32'h0);
                chk("R4 masked", 32'(sel_mask), 32'h0);
            end
        end

        // R6: period 256
        do_reset();
        full_mode = 2'd2;
        for (int e = 0; e <= 256; e++) begin
            send_evt();
            if (e == 0 || e == 256) chk("R6 256 forced", 32'(full_evt), 32'h1);
            else if (e == 128)      chk("R6 256 not at 128", 32'(full_evt), 32'h0);
        end

        // R6: period 1024
        do_reset();
        full_mode = 2'd3;
        for (int e = 0; e <= 1024; e++) begin
            send_evt();
            if (e == 0 || e == 1024)            chk("R6 1024 forced", 32'(full_evt), 32'h1);
            else if (e == 256 || e == 512)      chk("R6 1024 not early", 32'(full_evt), 32'h0);
        end

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule